// File: doc/BRIEF.md
# Toggle-Write Interrupt Status Router

This block collects internal trigger events into a 32-bit status word and forwards selected ones to processor threads. Hardware events set status bits. Software reads the word over a simple register bus. Writing a 1 to a bit inverts that bit, and writing a 0 leaves it alone. Because a 1 inverts, the same write can clear a pending bit or set a clear one.

Two of the triggers, bits 16 and 17, are routable, and each has its own vector register. When the vector's enable bit is set, its thread field picks one of four active-low thread lines. There is no mask register. A source is masked by writing its vector to zero. The status bit still records events while the source is unrouted.

A thread line goes low only on a 0-to-1 change of a routed status bit. The cause of that change can be a hardware event or a software toggle. The line stays low until software toggles the bit back to 0. Lines from several sources routed to the same thread are combined, so a line is low while any of them is pending.

Top module: `tws_router`

## Requirements
- R1: After reset, the status word reads 0, both vector registers read 0, and all four thread lines `thr_irq_no` are high.
- R2: A bus write to address 0x00 inverts every status bit whose write-data bit is 1. Bits written with 0 keep their value. The status word reads back at address 0x00.
- R3: An `evt_i` bit set in a cycle leaves the matching status bit at 1 after that clock edge. This holds whether the bit was 0 or 1 before.
- R4: When an event and a toggle write hit the same status bit in the same cycle, the bit ends at 1.
- R5: Vector register bits [1:0] select the thread and bit 2 enables routing. When a routed status bit (16 or 17) changes from 0 to 1, thread line `thr_irq_no[sel]` is low after that same clock edge.
- R6: A thread line that went low stays low until its source status bit is toggled back to 0. The line returns high after the edge of that write.
- R7: While a vector's enable bit is 0, its source drives no thread line, but the source's status bit is still set by events.
- R8: For a status bit that is already set, writing 1 (which clears the bit) and then writing 1 again (which sets it) produces a new assertion on the routed line.
- R9: Status bits other than 16 and 17 never affect the thread lines.
- R10: When both sources are routed to the same thread, that line is low while either source is pending.
- R11: The vector for trigger 16 is at address 0x10 and the vector for trigger 17 is at 0x18. Each stores only write-data bits [2:0], and reads return them zero-extended.
- R12: Routing a source whose status bit is already 1 does not assert a line, because only an edge asserts one. Unrouting a pending source releases its line right away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Hardware trigger events, one per status bit |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for the register at `bus_addr_i` |
| thr_irq_no | output | 4 | Per-thread interrupt lines, active low |

## Verification
A hardware event and a software toggle can land on the same status bit in the same clock cycle. This case matters most because it decides both the final bit value and whether an edge is reported. It is provoked directly, once on a clear bit and once on a set bit. It also occurs throughout a long random run in which events and status writes overlap freely. The bench's own model applies the rule that the event wins, then compares the status word read back and all four thread lines on every cycle.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int unsigned THR_SEL_W = 2;
  localparam int unsigned NUM_THR   = 1 << THR_SEL_W;
  localparam int unsigned VEC_W     = THR_SEL_W + 1;  // [THR_SEL_W] = route enable
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/tws_status.sv
module tws_status #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] tog_i,
  output logic [NUM_SRC-1:0] stat_q_o,
  output logic [NUM_SRC-1:0] stat_d_o,
  output logic [NUM_SRC-1:0] rise_o
);
  logic [NUM_SRC-1:0] stat_q;

  // hardware set wins over a simultaneous toggle
  always_comb begin
    stat_d_o = (stat_q ^ tog_i) | evt_i;
    rise_o   = stat_d_o & ~stat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d_o;
  end

  assign stat_q_o = stat_q;

  p_hw_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tog_i == '0 && evt_i == '0) |=> $stable(stat_q));
endmodule

// File: rtl/tws_route_slot.sv
module tws_route_slot
  import tws_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vec_we_i,
  input  vec_t vec_wdata_i,
  input  logic stat_q_i,
  input  logic stat_d_i,
  input  logic rise_i,
  output vec_t vec_o,
  output logic pend_o
);
  vec_t vec_q, vec_d;
  logic pend_q, pend_d;

  always_comb begin
    vec_d  = vec_we_i ? vec_wdata_i : vec_q;
    // pending only via a routed edge; dropped when unrouted or bit cleared
    pend_d = stat_d_i && vec_d[VEC_W-1] && (pend_q || rise_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      vec_q  <= vec_d;
      pend_q <= pend_d;
    end
  end

  assign vec_o  = vec_q;
  assign pend_o = pend_q;

  p_edge_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> ($past(stat_q_i) == 1'b0));

  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_q_i |-> !pend_q);

  p_unrouted_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_q[VEC_W-1] |-> !pend_q);
endmodule

// File: rtl/tws_thread_merge.sv
module tws_thread_merge
  import tws_pkg::*;
#(
  parameter int unsigned NUM_ROUTE = 2
) (
  input  logic [NUM_ROUTE-1:0] pend_i,
  input  vec_t                 vec_i [NUM_ROUTE],
  output logic [NUM_THR-1:0]   irq_no
);
  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int k = 0; k < NUM_ROUTE; k++)
        if (pend_i[k] && vec_i[k][THR_SEL_W-1:0] == THR_SEL_W'(t)) hit = 1'b1;
    end
    assign irq_no[t] = ~hit;
  end
endmodule

// File: rtl/tws_router.sv
module tws_router
  import tws_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned ROUTE_BASE = 16,
  parameter int unsigned NUM_ROUTE  = 2,
  parameter int unsigned STAT_ADDR  = 'h00,
  parameter int unsigned VEC_ADDR   = 'h10,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [NUM_SRC-1:0] bus_wdata_i,
  output logic [NUM_SRC-1:0] bus_rdata_o,
  output logic [NUM_THR-1:0] thr_irq_no
);
  localparam logic [NUM_SRC-1:0] ROUTE_MASK =
    NUM_SRC'(((1 << NUM_ROUTE) - 1) << ROUTE_BASE);

  logic [NUM_SRC-1:0]   tog, stat_q, stat_d, rise;
  logic [NUM_ROUTE-1:0] vec_we, pend;
  vec_t                 vec [NUM_ROUTE];

  assign tog = (bus_we_i && bus_addr_i == ADDR_W'(STAT_ADDR)) ? bus_wdata_i : '0;

  tws_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .tog_i    (tog),
    .stat_q_o (stat_q),
    .stat_d_o (stat_d),
    .rise_o   (rise)
  );

  for (genvar k = 0; k < NUM_ROUTE; k++) begin : g_route
    assign vec_we[k] = bus_we_i && bus_addr_i == ADDR_W'(VEC_ADDR + k * VEC_STRIDE);
    tws_route_slot u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .vec_we_i    (vec_we[k]),
      .vec_wdata_i (bus_wdata_i[VEC_W-1:0]),
      .stat_q_i    (stat_q[ROUTE_BASE+k]),
      .stat_d_i    (stat_d[ROUTE_BASE+k]),
      .rise_i      (rise[ROUTE_BASE+k]),
      .vec_o       (vec[k]),
      .pend_o      (pend[k])
    );
  end

  tws_thread_merge #(.NUM_ROUTE(NUM_ROUTE)) u_merge (
    .pend_i (pend),
    .vec_i  (vec),
    .irq_no (thr_irq_no)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(STAT_ADDR)) bus_rdata_o = stat_q;
    for (int k = 0; k < NUM_ROUTE; k++)
      if (bus_addr_i == ADDR_W'(VEC_ADDR + k * VEC_STRIDE))
        bus_rdata_o = NUM_SRC'(vec[k]);
  end

  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ROUTE_MASK) == '0) |-> (&thr_irq_no));
endmodule

// File: tb/sim_tws_router.sv
module sim_tws_router;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] evt = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  lines;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] es = '0;
  logic [2:0]  ev [2] = '{3'd0, 3'd0};
  logic        ep [2] = '{1'b0, 1'b0};

  always #10 clk = ~clk;

  tws_router u0 (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .thr_irq_no(lines)
  );

  function automatic logic [3:0] exp_lines();
    logic [3:0] l = 4'hF;
    for (int k = 0; k < 2; k++)
      if (ep[k]) l[ev[k][1:0]] = 1'b0;
    return l;
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [7:0] a);
    if (a == 8'h00) return es;
    if (a == 8'h10) return {29'd0, ev[0]};
    if (a == 8'h18) return {29'd0, ev[1]};
    return 32'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [31:0] tg, sd, rs;
    logic [2:0]  vd;
    tg = (we && addr == 8'h00) ? wdata : 32'd0;
    sd = (es ^ tg) | evt;
    rs = sd & ~es;
    for (int k = 0; k < 2; k++) begin
      vd = (we && addr == 8'(8'h10 + 8 * k)) ? wdata[2:0] : ev[k];
      ep[k] = sd[16+k] && vd[2] && (ep[k] || rs[16+k]);
      ev[k] = vd;
    end
    es = sd;
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input string tag, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input logic [31:0] e, input logic [7:0] ra);
    we = w; addr = a; wdata = d; evt = e;
    @(posedge clk);
    model_step();
    @(negedge clk);
    we = 1'b0; evt = '0; addr = ra;
    #1;
    chk({tag, " rdata"}, rdata, exp_rdata(ra));
    chk({tag, " lines"}, {28'd0, lines}, {28'd0, exp_lines()});
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 status", 8'h00, 32'd0);
    rd("R1 vec0", 8'h10, 32'd0);
    rd("R1 vec1", 8'h18, 32'd0);
    chk("R1 lines", {28'd0, lines}, 32'hF);
    // R11 vector storage
    step("R11 vec0", 1, 8'h10, 32'hFF, 0, 8'h10);
    rd("R11 vec0 value", 8'h10, 32'h7);
    step("R11 vec1", 1, 8'h18, 32'h5, 0, 8'h18);
    rd("R11 vec1 value", 8'h18, 32'h5);
    step("R11 unrouted write", 1, 8'h10, 32'h0, 0, 8'h10);
    step("R11 clear vec1", 1, 8'h18, 32'h0, 0, 8'h18);
    // R2 toggle
    step("R2 set", 1, 8'h00, 32'hF0, 0, 8'h00);
    rd("R2 set value", 8'h00, 32'hF0);
    step("R2 toggle", 1, 8'h00, 32'h30, 0, 8'h00);
    rd("R2 toggle value", 8'h00, 32'hC0);
    step("R2 zero write", 1, 8'h00, 32'h0, 0, 8'h00);
    rd("R2 zero value", 8'h00, 32'hC0);
    // R3 events
    step("R3 event", 0, 8'h00, 0, 32'h1, 8'h00);
    step("R3 repeat event", 0, 8'h00, 0, 32'h1, 8'h00);
    rd("R3 value", 8'h00, 32'hC1);
    // R4 collision
    step("R4 clear bit", 1, 8'h00, 32'h100, 32'h100, 8'h00);
    step("R4 set bit", 1, 8'h00, 32'h1, 32'h1, 8'h00);
    rd("R4 value", 8'h00, 32'h1C1);
    step("R4 wipe", 1, 8'h00, 32'h1C1, 0, 8'h00);
    // R5/R6 routing
    step("R5 vec0", 1, 8'h10, 32'h7, 0, 8'h00);
    step("R5 vec1", 1, 8'h18, 32'h5, 0, 8'h00);
    step("R5 edge", 0, 8'h00, 0, 32'h10000, 8'h00);
    chk("R5 thread3 low", {28'd0, lines}, 32'h7);
    step("R6 hold", 0, 8'h00, 0, 32'h10000, 8'h00);
    step("R6 other toggle", 1, 8'h00, 32'h1, 0, 8'h00);
    chk("R6 still low", {28'd0, lines}, 32'h7);
    step("R6 clear", 1, 8'h00, 32'h10001, 0, 8'h00);
    chk("R6 released", {28'd0, lines}, 32'hF);
    // R10 shared thread
    step("R10 vec1", 1, 8'h18, 32'h7, 0, 8'h00);
    step("R10 both", 0, 8'h00, 0, 32'h30000, 8'h00);
    step("R10 drop16", 1, 8'h00, 32'h10000, 0, 8'h00);
    chk("R10 still low", {28'd0, lines}, 32'h7);
    step("R10 drop17", 1, 8'h00, 32'h20000, 0, 8'h00);
    chk("R10 released", {28'd0, lines}, 32'hF);
    // R7 unrouted
    step("R7 unroute", 1, 8'h10, 32'h0, 0, 8'h00);
    step("R7 event", 0, 8'h00, 0, 32'h10000, 8'h00);
    chk("R7 lines high", {28'd0, lines}, 32'hF);
    rd("R7 status kept", 8'h00, 32'h10000);
    // R12 route on set bit, R8 retrigger
    step("R12 route set bit", 1, 8'h10, 32'h6, 0, 8'h00);
    chk("R12 no edge", {28'd0, lines}, 32'hF);
    step("R8 clear", 1, 8'h00, 32'h10000, 0, 8'h00);
    step("R8 reset bit", 1, 8'h00, 32'h10000, 0, 8'h00);
    chk("R8 retrigger", {28'd0, lines}, 32'hB);
    step("R12 unroute", 1, 8'h10, 32'h0, 0, 8'h00);
    chk("R12 released", {28'd0, lines}, 32'hF);
    // R9 other bits
    step("R9 reroute", 1, 8'h10, 32'h4, 0, 8'h00);
    step("R9 clear", 1, 8'h00, es, 0, 8'h00);
    step("R9 others", 0, 8'h00, 0, 32'hFFFC_FFFF, 8'h00);
    chk("R9 lines high", {28'd0, lines}, 32'hF);
    // random mix: R2 R3 R4 R5 R6 R10 via model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0]  a;
      logic [31:0] d, e;
      case ($urandom % 4)
        0, 1: a = 8'h00;
        2: a = 8'h10;
        default: a = 8'h18;
      endcase
      if (($urandom % 8) == 0) a = 8'h18 - a[3:0];
      d = $urandom & $urandom & $urandom;
      if (a != 8'h00) d = {29'd0, 3'($urandom)};
      e = $urandom & $urandom & $urandom & $urandom;
      if (($urandom % 4) == 0) e = e | (32'h3 << 16);
      step("R4 random", 1'($urandom), a, d, e, 8'(($urandom % 2) ? 8'h00 : 8'h10));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule